// File: doc/BRIEF.md
# Transmit Test-Pattern Register Bank

This block sits on a simple 32-bit register interface and serves two address windows. The low window passes writes and reads through to an external offload engine's register file. The local window holds a small set of control and status registers.

The local registers drive a transmit pattern generator. After software programs a byte length and writes the command register, the generator pushes incrementing 32-bit words into a FIFO write port. It holds off while the FIFO reports full and stops once the programmed length has been covered.

The same local window also does the following:
- Counts received words reported by an external verifier.
- Latches that verifier's mismatch flag when verification is enabled.
- Keeps a sticky copy of a timer-interrupt input.
- Reports FIFO status.
- Issues a self-clearing soft-reset pulse to the user logic.

Top module: `tpg_regbank`

## Requirements
- R1: Address bits [12:8] equal to 0 select the engine window. A write there raises `eng_wr_en` in the same cycle, and a read returns `eng_rd_data`. Bits [12:8] equal to 5'b10000 with bits [1:0] zero select the local window, where bits [7:2] index a register. Any other address is unmapped: a write to it does nothing and a read returns 0.
- R2: Read data appears on `reg_rd_data` one clock after `reg_rd_req`. `reg_rd_valid` is `reg_rd_req` delayed by one flip-flop.
- R3: `reg_wr_be` is ignored, and every write updates all 32 bits.
- R4: A write to local offset 0x00 sets the transmit length in bytes. A read of offset 0x00 returns the bytes sent so far.
- R5: Any write to local offset 0x04 does the following. It clears the sent and received byte counters and the fail flag. It loads the verify enable (`verify_en`) from data bit 1. It starts transmission when the length is nonzero. A read of offset 0x04 returns bit 0 = busy and bit 1 = verify fail, with all other bits 0.
- R6: While busy, `fifo_wr_en` equals NOT `fifo_full`. `fifo_wr_data` starts at 0 and increases by 1 with each accepted write.
- R7: Each accepted FIFO write adds 4 to the sent counter. Busy clears on the write that brings the counter to at least the length. A length L therefore yields ceil(L/4) words and a final count of 4*ceil(L/4).
- R8: A write to local offset 0x08 with bit 0 set does two things. It produces a one-cycle `user_rst` pulse in the following cycle. It also clears busy, both byte counters and the fail flag.
- R9: A high `timer_irq` sets a sticky flag that reads back at bit 8 of offset 0x08. A write to offset 0x08 with bit 8 set clears the flag, unless `timer_irq` is high in the same cycle.
- R10: A read of offset 0x0C returns `rx_fifo_count` in bits [15:0] and `fifo_full` in bit 24, with all other bits 0.
- R11: Each cycle with `rx_word_en` high adds 4 to the received counter, which reads back at offset 0x10. When verify is enabled, `rx_word_en` together with `rx_mismatch` sets the fail flag.
- R12: Reads of local offsets 0x14 to 0xFC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_req | input | 1 | Register read request |
| reg_addr | input | 13 | Register byte address |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables (ignored) |
| reg_rd_data | output | 32 | Registered read data |
| reg_rd_valid | output | 1 | Read data valid |
| eng_wr_en | output | 1 | Write strobe to engine window |
| eng_rd_data | input | 32 | Engine register read data for `reg_addr` |
| fifo_full | input | 1 | Transmit FIFO full |
| fifo_wr_en | output | 1 | Transmit FIFO write enable |
| fifo_wr_data | output | 32 | Transmit pattern word |
| rx_fifo_count | input | 16 | Receive FIFO fill count |
| rx_word_en | input | 1 | One received word consumed |
| rx_mismatch | input | 1 | Consumed word did not match |
| verify_en | output | 1 | Receive verification enable |
| timer_irq | input | 1 | Timer interrupt to latch |
| user_rst | output | 1 | Soft-reset pulse to user logic |

## Verification
Several properties are checked on every cycle:
- The read-valid pipeline.
- The +4 counter step on each accepted FIFO write.
- That busy only drops once the count has reached the length.
- That a command write leaves both counters at zero.
- That the soft-reset pulse coincides with cleared state.
- The sticky timer latch.

Other behaviours can only be shown by the bench's scenarios. These are the exact word count and data sequence for each length under a throttling full pattern, the window decode across the whole address range, the status bit layout, and the ignored byte enables. The bench sweeps every length from 1 to 16 and every engine word.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
    // Local register index (address bits [7:2])
    typedef enum logic [5:0] {
        LOC_LEN = 6'd0,
        LOC_CMD = 6'd1,
        LOC_RST = 6'd2,
        LOC_STS = 6'd3,
        LOC_RXC = 6'd4
    } loc_idx_e;

    localparam int NUM_LOC      = 5;
    localparam int CMD_VERIFY   = 1;
    localparam int RST_SOFT     = 0;
    localparam int RST_TMR      = 8;
    localparam int STS_FULL_BIT = 24;
    localparam int BYTES_PER_W  = 4;
endpackage

// File: rtl/tpg_txgen.sv
`timescale 1ns/1ps
module tpg_txgen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] len_i,
    input  logic              fifo_full_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              fifo_wr_en_o,
    output logic [DATA_W-1:0] fifo_wr_data_o
);
    import tpg_pkg::*;

    localparam int SHIFT = $clog2(BYTES_PER_W);

    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] cnt;
    } tx_t;

    tx_t tx_d, tx_q;
    logic          accept;
    logic [DATA_W:0] sum;

    always_comb begin
        tx_d   = tx_q;
        accept = tx_q.busy & ~fifo_full_i;
        sum    = {1'b0, tx_q.cnt} + (DATA_W+1)'(BYTES_PER_W);
        if (clr_i) begin
            tx_d = '0;
        end else if (start_i) begin
            tx_d.cnt  = '0;
            tx_d.busy = |len_i;
        end else if (accept) begin
            tx_d.cnt = sum[DATA_W-1:0];
            if (sum >= {1'b0, len_i})
                tx_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign busy_o         = tx_q.busy;
    assign cnt_o          = tx_q.cnt;
    assign fifo_wr_en_o   = accept;
    assign fifo_wr_data_o = DATA_W'(tx_q.cnt >> SHIFT);

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en_o && !clr_i && !start_i) |=> cnt_o == $past(cnt_o) + DATA_W'(BYTES_PER_W));

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(clr_i) && !$past(start_i))
            |-> (cnt_o == '0 || cnt_o >= $past(len_i)));
endmodule

// File: rtl/tpg_rdmux.sv
`timescale 1ns/1ps
module tpg_rdmux #(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int NUM_LOC = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_req_i,
    input  logic                            eng_sel_i,
    input  logic                            loc_sel_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [DATA_W-1:0]               eng_data_i,
    input  logic [NUM_LOC-1:0][DATA_W-1:0]  loc_words_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic                            rd_valid_o
);
    localparam int SEL_W = $clog2(NUM_LOC);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        if (eng_sel_i)
            mux = eng_data_i;
        else if (loc_sel_i && (idx_i < IDX_W'(NUM_LOC)))
            mux = loc_words_i[idx_i[SEL_W-1:0]];
        rd_d       = rd_q;
        rd_d.valid = rd_req_i;
        if (rd_req_i) rd_d.data = mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o  = rd_q.data;
    assign rd_valid_o = rd_q.valid;

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> (!rd_valid_o && $stable(rd_data_o)));
endmodule

// File: rtl/tpg_regbank.sv
`timescale 1ns/1ps
module tpg_regbank #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 32,
    parameter int FCNT_W  = 16,
    parameter int WIN_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [3:0]        reg_wr_be,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_rd_valid,
    output logic              eng_wr_en,
    input  logic [DATA_W-1:0] eng_rd_data,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    input  logic [FCNT_W-1:0] rx_fifo_count,
    input  logic              rx_word_en,
    input  logic              rx_mismatch,
    output logic              verify_en,
    input  logic              timer_irq,
    output logic              user_rst
);
    import tpg_pkg::*;

    localparam int WIN_W = ADDR_W - WIN_LSB;
    localparam int IDX_W = WIN_LSB - 2;
    localparam logic [WIN_W-1:0] LOC_WIN = WIN_W'(1) << (WIN_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] rxcnt;
        logic              verify;
        logic              fail;
        logic              tmr;
        logic              urst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             eng_sel, loc_sel, wr_loc, start, srst, tmr_clr;
    logic [IDX_W-1:0] idx;
    logic             tx_busy;
    logic [DATA_W-1:0] tx_cnt;
    logic [NUM_LOC-1:0][DATA_W-1:0] loc_words;

    // Window decode; byte enables deliberately unused
    always_comb begin
        eng_sel = (reg_addr[ADDR_W-1:WIN_LSB] == '0);
        loc_sel = (reg_addr[ADDR_W-1:WIN_LSB] == LOC_WIN) && (reg_addr[1:0] == 2'b00);
        idx     = reg_addr[WIN_LSB-1:2];
        wr_loc  = reg_wr_en & loc_sel;
        start   = wr_loc && (idx == IDX_W'(LOC_CMD));
        srst    = wr_loc && (idx == IDX_W'(LOC_RST)) && reg_wr_data[RST_SOFT];
        tmr_clr = wr_loc && (idx == IDX_W'(LOC_RST)) && reg_wr_data[RST_TMR];
    end

    assign eng_wr_en = reg_wr_en & eng_sel;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.urst = 1'b0;
        if (wr_loc && idx == IDX_W'(LOC_LEN))
            ctl_d.len = reg_wr_data;
        if (rx_word_en)
            ctl_d.rxcnt = ctl_q.rxcnt + DATA_W'(BYTES_PER_W);
        if (rx_word_en && rx_mismatch && ctl_q.verify)
            ctl_d.fail = 1'b1;
        if (start) begin
            ctl_d.verify = reg_wr_data[CMD_VERIFY];
            ctl_d.rxcnt  = '0;
            ctl_d.fail   = 1'b0;
        end
        if (srst) begin
            ctl_d.urst  = 1'b1;
            ctl_d.rxcnt = '0;
            ctl_d.fail  = 1'b0;
        end
        if (tmr_clr)   ctl_d.tmr = 1'b0;
        if (timer_irq) ctl_d.tmr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign verify_en = ctl_q.verify;
    assign user_rst  = ctl_q.urst;

    tpg_txgen #(.DATA_W(DATA_W)) u_txgen (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (srst),
        .start_i        (start),
        .len_i          (ctl_q.len),
        .fifo_full_i    (fifo_full),
        .busy_o         (tx_busy),
        .cnt_o          (tx_cnt),
        .fifo_wr_en_o   (fifo_wr_en),
        .fifo_wr_data_o (fifo_wr_data)
    );

    always_comb begin
        loc_words          = '0;
        loc_words[LOC_LEN] = tx_cnt;
        loc_words[LOC_CMD][0]          = tx_busy;
        loc_words[LOC_CMD][CMD_VERIFY] = ctl_q.fail;
        loc_words[LOC_RST][RST_TMR]    = ctl_q.tmr;
        loc_words[LOC_STS][FCNT_W-1:0]  = rx_fifo_count;
        loc_words[LOC_STS][STS_FULL_BIT] = fifo_full;
        loc_words[LOC_RXC] = ctl_q.rxcnt;
    end

    tpg_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_LOC(NUM_LOC)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (reg_rd_req),
        .eng_sel_i   (eng_sel),
        .loc_sel_i   (loc_sel),
        .idx_i       (idx),
        .eng_data_i  (eng_rd_data),
        .loc_words_i (loc_words),
        .rd_data_o   (reg_rd_data),
        .rd_valid_o  (reg_rd_valid)
    );

    // R5
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !srst) |=> (tx_cnt == '0 && ctl_q.rxcnt == '0 && !ctl_q.fail));

    // R8
    urst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_rst |-> (!tx_busy && tx_cnt == '0 && ctl_q.rxcnt == '0 && !ctl_q.fail));

    // R9
    tmr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |=> ctl_q.tmr);

    // R9
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.tmr && !tmr_clr) |=> ctl_q.tmr);
endmodule

// File: tb/tpg_regbank_test.sv
`timescale 1ns/1ps
module tpg_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_req = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_wr_be = 4'hF;
    logic [31:0] reg_rd_data, eng_rd_data, fifo_wr_data;
    logic        reg_rd_valid, eng_wr_en, fifo_wr_en, verify_en, user_rst;
    logic        fifo_full = 1'b0;
    logic [15:0] rx_fifo_count = '0;
    logic        rx_word_en = 1'b0, rx_mismatch = 1'b0, timer_irq = 1'b0;

    int n_vec = 0, n_bad = 0, cyc = 0, words = 0, thr_mod = 2;
    bit thr_en = 1'b0, hold_full = 1'b0, done = 1'b0;
    logic [31:0] rd_val;

    always #4 clk = ~clk;

    assign eng_rd_data = {16'hE0E0, 3'b000, reg_addr};

    tpg_regbank uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // FIFO full driver and word monitor
    always @(negedge clk) begin
        cyc++;
        fifo_full = hold_full | (thr_en && (cyc % thr_mod == 0));
        #1;
        if (fifo_wr_en) begin
            chk("R6 word", fifo_wr_data, 32'(words));
            words++;
        end
        if (thr_en && uut.u_txgen.busy_o === 1'bx) chk("R6 busy", 0, 1);
    end

    task automatic wr(logic [12:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
        #2;
        chk("R1 eng_wr_en", 32'(eng_wr_en), 32'(a[12:8] == 5'd0));
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_req = 1'b1;
        @(negedge clk);
        #2;
        chk("R2 valid", 32'(reg_rd_valid), 1);
        d = reg_rd_data;
        reg_rd_req = 1'b0;
        @(negedge clk);
        #2;
        chk("R2 valid drop", 32'(reg_rd_valid), 0);
    endtask

    task automatic rchk(string req, logic [12:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(13'h1004, v);
            if (v[0] == 1'b0) return;
        end
        chk("R7 busy timeout", 1, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        #2;
        chk("R2 reset valid", 32'(reg_rd_valid), 0);
        chk("R2 reset data", reg_rd_data, 0);
        chk("R6 reset wr_en", 32'(fifo_wr_en), 0);
        rst_n = 1'b1;
        rchk("R5 reset cmd", 13'h1004, 0);
        rchk("R4 reset count", 13'h1000, 0);

        // R1: whole engine window reads back, engine writes strobe
        for (int w = 0; w < 64; w++)
            rchk("R1 engine read", 13'(w * 4), {16'hE0E0, 3'b000, 13'(w * 4)});
        wr(13'h0010, 32'h1234);
        wr(13'h0100, 32'h55);
        rchk("R1 unmapped gap", 13'h0100, 0);
        rchk("R1 unmapped high", 13'h1100, 0);
        rchk("R1 misaligned local", 13'h1001, 0);
        // R12
        for (int o = 5; o < 64; o++)
            rchk("R12 unmapped local", 13'h1000 + 13'(o * 4), 0);

        // R4 R6 R7: length sweep with throttled FIFO
        thr_en = 1'b1;
        for (int L = 1; L <= 16; L++) begin
            thr_mod = (L % 3) + 2;
            wr(13'h1000, 32'(L));
            words = 0;
            wr(13'h1004, 32'h0);
            wait_idle();
            chk("R7 word count", 32'(words), 32'((L + 3) / 4));
            rchk("R4 sent bytes", 13'h1000, 32'(4 * ((L + 3) / 4)));
        end
        thr_en = 1'b0;

        // R5: zero length does not start
        wr(13'h1000, 32'h0);
        words = 0;
        wr(13'h1004, 32'h0);
        repeat (4) @(negedge clk);
        chk("R5 zero length", 32'(words), 0);
        rchk("R5 zero busy", 13'h1004, 0);

        // R3: byte enables ignored
        wr(13'h1000, 32'h0000_0008, 4'h0);
        words = 0;
        wr(13'h1004, 32'h0);
        wait_idle();
        chk("R3 full word written", 32'(words), 2);

        // R6: fully stalled FIFO
        hold_full = 1'b1;
        wr(13'h1000, 32'd40);
        words = 0;
        wr(13'h1004, 32'h0);
        repeat (6) @(negedge clk);
        chk("R6 stall", 32'(words), 0);
        rchk("R5 busy bit", 13'h1004, 32'h1);
        // R10 while full
        rx_fifo_count = 16'hBEEF;
        rchk("R10 status", 13'h100C, 32'h0100_BEEF);
        // R8: soft reset
        wr(13'h1008, 32'h1);
        #2;
        chk("R8 pulse", 32'(user_rst), 1);
        @(negedge clk);
        #2;
        chk("R8 pulse end", 32'(user_rst), 0);
        rchk("R8 busy cleared", 13'h1004, 0);
        rchk("R8 count cleared", 13'h1000, 0);
        hold_full = 1'b0;
        rx_fifo_count = 16'h0012;
        repeat (2) @(negedge clk);
        rchk("R10 status empty", 13'h100C, 32'h0000_0012);

        // R11: received counter and verify flag
        wr(13'h1000, 32'h0);
        wr(13'h1004, 32'h2);
        chk("R5 verify_en", 32'(verify_en), 1);
        @(negedge clk);
        rx_word_en = 1'b1;
        repeat (7) @(negedge clk);
        rx_word_en = 1'b0;
        rchk("R11 rx bytes", 13'h1010, 32'd28);
        rchk("R11 no fail", 13'h1004, 0);
        @(negedge clk);
        rx_word_en = 1'b1; rx_mismatch = 1'b1;
        @(negedge clk);
        rx_word_en = 1'b0; rx_mismatch = 1'b0;
        rchk("R11 fail set", 13'h1004, 32'h2);
        wr(13'h1004, 32'h0);
        rchk("R5 rx cleared", 13'h1010, 0);
        rchk("R5 fail cleared", 13'h1004, 0);
        chk("R5 verify off", 32'(verify_en), 0);
        @(negedge clk);
        rx_word_en = 1'b1; rx_mismatch = 1'b1;
        @(negedge clk);
        rx_word_en = 1'b0; rx_mismatch = 1'b0;
        rchk("R11 fail masked", 13'h1004, 0);
        rchk("R11 rx one", 13'h1010, 32'd4);
        wr(13'h1008, 32'h1);
        rchk("R8 rx cleared", 13'h1010, 0);

        // R9: timer latch
        rchk("R9 latch idle", 13'h1008, 0);
        @(negedge clk);
        timer_irq = 1'b1;
        @(negedge clk);
        timer_irq = 1'b0;
        rchk("R9 latch set", 13'h1008, 32'h100);
        rchk("R9 latch held", 13'h1008, 32'h100);
        wr(13'h1008, 32'h100);
        rchk("R9 latch cleared", 13'h1008, 0);
        @(negedge clk);
        timer_irq = 1'b1; reg_addr = 13'h1008; reg_wr_data = 32'h100; reg_wr_en = 1'b1;
        @(negedge clk);
        timer_irq = 1'b0; reg_wr_en = 1'b0;
        rchk("R9 set wins", 13'h1008, 32'h100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule